// File: doc/BRIEF.md
# Effective Address Generator

This block forms a memory address, or a plain arithmetic value, in one registered step. A request carries a base register value, an index register value with a 2-bit scale code, a signed displacement, the program counter, an optional hidden segment base and a mode. One clock edge after a valid request, the block presents the result. It also presents a signed-overflow status flag for the last addition, and, in the post-increment mode, a writeback value for the base register.

Four modes are supported. The indexed mode adds base, scaled index, displacement and segment. The post-increment mode sends the unmodified base out as the address and asks for the base register to be advanced by one element. The PC-relative mode adds the displacement to the program counter. The arithmetic mode returns the indexed sum as a value and leaves the status flag as it was. All sums are taken modulo 2^AW. Translation, permission checks and the memory access itself are done by other blocks.

Top module: `agu_top`

## Requirements
- R1: While rst_ni is low, res_valid_o, res_o, res_is_addr_o, wrap_o, wb_en_o and wb_data_o are all 0.
- R2: A valid request with mode_i = 0 (indexed) gives res_o = base_i + index_i * (1 << scale_i) + sext(disp_i), modulo 2^AW, with res_valid_o = 1 and res_is_addr_o = 1 on the clock edge that samples the request. Scale codes 0, 1, 2 and 3 select factors 1, 2, 4 and 8.
- R3: disp_i is a DW-bit two's complement value and is sign-extended to AW bits. With DW = 16, the pattern 0x9C40 adds -25536.
- R4: Sums wrap modulo 2^AW. With AW = 32, 0xFFFFFFFE + 5 gives 0x00000003, and 0x00000003 - 5 gives 0xFFFFFFFE.
- R5: wrap_o is the carry into bit AW-1 XOR the carry out of bit AW-1 of the final addition A + B. For modes 0 and 3, A = base + scaled index + segment and B = sext(disp). For mode 1, A = base and B = segment. For mode 2, A = pc_i and B = sext(disp).
- R6: For a valid request with mode_i = 1 (post-increment), res_o = base_i plus the segment, and wb_en_o pulses for one cycle with wb_data_o = base_i + (1 << scale_i). wb_data_o holds its value otherwise.
- R7: For a valid request with mode_i = 2 (PC-relative), res_o = pc_i + sext(disp_i). base_i, index_i and the segment have no effect on the result.
- R8: When seg_en_i = 1, seg_base_i is added in modes 0, 1 and 3. When seg_en_i = 0, seg_base_i has no effect.
- R9: For a valid request with mode_i = 3 (arithmetic), res_o is the mode-0 sum, res_is_addr_o = 0, and wrap_o keeps its previous value.
- R10: A cycle with req_valid_i = 0 gives res_valid_o = 0 and wb_en_o = 0 on the next edge. res_o, wrap_o and wb_data_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request qualifier |
| mode_i | input | 2 | 0 indexed, 1 post-increment, 2 PC-relative, 3 arithmetic |
| seg_en_i | input | 1 | Add the segment base |
| seg_base_i | input | AW | Hidden segment base |
| base_i | input | AW | Base register value |
| index_i | input | AW | Index register value |
| scale_i | input | 2 | Index scale code, factor 1 << code |
| disp_i | input | DW | Signed displacement |
| pc_i | input | AW | Program counter |
| res_valid_o | output | 1 | Result valid, one cycle after request |
| res_o | output | AW | Address or arithmetic value |
| res_is_addr_o | output | 1 | 1 for address modes, 0 for arithmetic |
| wrap_o | output | 1 | Signed-overflow status of the final addition |
| wb_en_o | output | 1 | Base register writeback strobe |
| wb_data_o | output | AW | Incremented base for writeback |

## Verification
The indexed mode is run with the same base, index and displacement under each of the four scale codes. A wrong shift shows up as a distinct wrong value for each code. Displacements with the top bit set, together with bases near zero and near all-ones, separate a missing sign extension from correct modular wrap. Operands at the signed boundaries, 0x7FFFFFFF + 1 and 0x80000000 - 1, separate a true carry-in XOR carry-out flag from a plain carry-out flag. An arithmetic request issued after the flag has been set shows whether it leaves the flag alone. Random mixed-mode traffic with gaps between requests then checks every output against the reference on every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_INDEXED = 2'd0,
    AGU_POSTINC = 2'd1,
    AGU_PCREL   = 2'd2,
    AGU_ARITH   = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_scaler.sv
module agu_scaler #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic [AW-1:0] idx_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] scaled_o,
  output logic [AW-1:0] elem_size_o
);
  localparam int NSCALE = 1 << SW;

  logic [AW-1:0] shifted [NSCALE];
  logic [AW-1:0] sizes   [NSCALE];

  for (genvar s = 0; s < NSCALE; s++) begin : g_scale
    assign shifted[s] = idx_i << s;
    assign sizes[s]   = AW'(1) << s;
  end

  assign scaled_o    = shifted[scale_i];
  assign elem_size_o = sizes[scale_i];
endmodule

// File: rtl/agu_opsel.sv
module agu_opsel
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  agu_mode_e     mode_i,
  input  logic          seg_en_i,
  input  logic [AW-1:0] seg_base_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] scaled_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] op_a_o,
  output logic [AW-1:0] op_b_o
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] disp_sx;
  logic [AW-1:0] seg_v;

  assign disp_sx = {{EXT{disp_i[DW-1]}}, disp_i};
  assign seg_v   = seg_en_i ? seg_base_i : '0;

  always_comb begin
    unique case (mode_i)
      AGU_POSTINC: begin
        op_a_o = base_i;
        op_b_o = seg_v;
      end
      AGU_PCREL: begin
        op_a_o = pc_i;
        op_b_o = disp_sx;
      end
      default: begin
        op_a_o = base_i + scaled_i + seg_v;
        op_b_o = disp_sx;
      end
    endcase
  end
endmodule

// File: rtl/agu_wrap_add.sv
module agu_wrap_add #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] sum_o,
  output logic          ovf_o
);
  logic [AW-1:0] low;
  logic [AW:0]   full;
  logic          c_msb_in;

  // carry into the top bit comes from the low AW-1 bits
  assign low      = {1'b0, a_i[AW-2:0]} + {1'b0, b_i[AW-2:0]};
  assign c_msb_in = low[AW-1];
  assign full     = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o    = full[AW-1:0];
  assign ovf_o    = c_msb_in ^ full[AW];
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    mode_i,
  input  logic          seg_en_i,
  input  logic [AW-1:0] seg_base_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [1:0]    scale_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] pc_i,
  output logic          res_valid_o,
  output logic [AW-1:0] res_o,
  output logic          res_is_addr_o,
  output logic          wrap_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o
);
  agu_mode_e     mode;
  logic [AW-1:0] scaled, elem_size, op_a, op_b, sum;
  logic          ovf;

  assign mode = agu_mode_e'(mode_i);

  agu_scaler #(.AW(AW), .SW(2)) u_scaler (
    .idx_i      (index_i),
    .scale_i    (scale_i),
    .scaled_o   (scaled),
    .elem_size_o(elem_size)
  );

  agu_opsel #(.AW(AW), .DW(DW)) u_opsel (
    .mode_i    (mode),
    .seg_en_i  (seg_en_i),
    .seg_base_i(seg_base_i),
    .base_i    (base_i),
    .scaled_i  (scaled),
    .disp_i    (disp_i),
    .pc_i      (pc_i),
    .op_a_o    (op_a),
    .op_b_o    (op_b)
  );

  agu_wrap_add #(.AW(AW)) u_add (
    .a_i  (op_a),
    .b_i  (op_b),
    .sum_o(sum),
    .ovf_o(ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o   <= 1'b0;
      res_o         <= '0;
      res_is_addr_o <= 1'b0;
      wrap_o        <= 1'b0;
      wb_en_o       <= 1'b0;
      wb_data_o     <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      wb_en_o     <= req_valid_i && (mode == AGU_POSTINC);
      if (req_valid_i) begin
        res_o         <= sum;
        res_is_addr_o <= (mode != AGU_ARITH);
        if (mode != AGU_ARITH) wrap_o <= ovf;
        if (mode == AGU_POSTINC) wb_data_o <= base_i + elem_size;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    mode_i,
  input logic          seg_en_i,
  input logic [AW-1:0] seg_base_i,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] index_i,
  input logic [1:0]    scale_i,
  input logic [DW-1:0] disp_i,
  input logic [AW-1:0] pc_i,
  input logic          res_valid_o,
  input logic [AW-1:0] res_o,
  input logic          res_is_addr_o,
  input logic          wrap_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_data_o
);
  localparam int EXT = AW - DW;

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o && !wb_en_o && $stable(res_o) && $stable(wrap_o) && $stable(wb_data_o));

  assert_arith_keeps_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd3) |=> $stable(wrap_o) && !res_is_addr_o);

  assert_postinc_wb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd1) |=>
      wb_en_o && wb_data_o == $past(base_i) + (AW'(1) << $past(scale_i)));

  assert_postinc_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd1) |=>
      res_o == $past(base_i) + ($past(seg_en_i) ? $past(seg_base_i) : '0));

  assert_pcrel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd2) |=>
      res_o == $past(pc_i) + {{EXT{$past(disp_i[DW-1])}}, $past(disp_i)});

  assert_wb_only_with_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> res_valid_o && res_is_addr_o);
endmodule

bind agu_top agu_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .mode_i       (mode_i),
  .seg_en_i     (seg_en_i),
  .seg_base_i   (seg_base_i),
  .base_i       (base_i),
  .index_i      (index_i),
  .scale_i      (scale_i),
  .disp_i       (disp_i),
  .pc_i         (pc_i),
  .res_valid_o  (res_valid_o),
  .res_o        (res_o),
  .res_is_addr_o(res_is_addr_o),
  .wrap_o       (wrap_o),
  .wb_en_o      (wb_en_o),
  .wb_data_o    (wb_data_o)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;
  localparam int AW = 32;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [1:0]    mode = '0;
  logic          seg_en = 1'b0;
  logic [AW-1:0] seg = '0, base = '0, idx = '0, pc = '0;
  logic [1:0]    sc = '0;
  logic [DW-1:0] disp = '0;
  logic          res_valid, is_addr, wrap, wb_en;
  logic [AW-1:0] res, wb_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string in_tag = "R10", exp_tag = "R1";

  always #4 clk = ~clk;

  agu_top #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .mode_i(mode),
    .seg_en_i(seg_en), .seg_base_i(seg), .base_i(base), .index_i(idx),
    .scale_i(sc), .disp_i(disp), .pc_i(pc),
    .res_valid_o(res_valid), .res_o(res), .res_is_addr_o(is_addr),
    .wrap_o(wrap), .wb_en_o(wb_en), .wb_data_o(wb_data)
  );

  // behavioural reference
  logic          e_valid, e_isaddr, e_wrap, e_wben;
  logic [AW-1:0] e_res, e_wbdata;

  always @(posedge clk or negedge rst_n) begin
    logic [AW-1:0] a, b, s, dsx, segv;
    if (!rst_n) begin
      e_valid = 0; e_isaddr = 0; e_wrap = 0; e_wben = 0; e_res = 0; e_wbdata = 0;
      exp_tag = "R1";
    end else begin
      exp_tag = in_tag;
      e_valid = valid;
      e_wben = valid && mode == 2'd1;
      if (valid) begin
        dsx = AW'($signed(disp));
        segv = seg_en ? seg : 0;
        if (mode == 2'd1) begin a = base; b = segv; end
        else if (mode == 2'd2) begin a = pc; b = dsx; end
        else begin a = base + idx * (1 << sc) + segv; b = dsx; end
        s = a + b;
        e_res = s;
        e_isaddr = mode != 2'd3;
        if (mode != 2'd3) e_wrap = (a[AW-1] == b[AW-1]) && (s[AW-1] != a[AW-1]);
        if (mode == 2'd1) e_wbdata = base + (1 << sc);
      end
    end
  end

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle compare against reference
  always @(negedge clk) begin
    if (!done) begin
      chk(exp_tag, "res_valid", AW'(res_valid), AW'(e_valid));
      chk(exp_tag, "res", res, e_res);
      chk(exp_tag, "is_addr", AW'(is_addr), AW'(e_isaddr));
      chk(exp_tag, "wrap", AW'(wrap), AW'(e_wrap));
      chk(exp_tag, "wb_en", AW'(wb_en), AW'(e_wben));
      chk(exp_tag, "wb_data", wb_data, e_wbdata);
    end
  end

  task automatic req(string tag, logic [1:0] m, logic se, logic [AW-1:0] sg,
                     logic [AW-1:0] b, logic [AW-1:0] ix, logic [1:0] s,
                     logic [DW-1:0] d, logic [AW-1:0] p);
    in_tag = tag; valid = 1; mode = m; seg_en = se; seg = sg;
    base = b; idx = ix; sc = s; disp = d; pc = p;
    @(negedge clk);
    valid = 0; in_tag = "R10";
  endtask

  task automatic summary();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset res_valid", AW'(res_valid), 0);
    chk("R1", "reset res", res, 0);
    chk("R1", "reset wrap", AW'(wrap), 0);
    chk("R1", "reset wb_en", AW'(wb_en), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 scale codes
    for (int s = 0; s < 4; s++) begin
      req("R2", 2'd0, 0, 0, 32'h1000, 32'd3, 2'(s), 16'h0010, 0);
      chk("R2", "scaled ea", res, 32'h1010 + 32'd3 * (32'd1 << s));
    end
    // R3 negative displacement
    req("R3", 2'd0, 0, 0, 32'h0010_0000, 0, 0, 16'h9C40, 0);
    chk("R3", "sext disp", res, 32'h000F_9C40);
    // R4 modular wrap both ways
    req("R4", 2'd0, 0, 0, 32'hFFFF_FFFE, 0, 0, 16'd5, 0);
    chk("R4", "wrap up", res, 32'h0000_0003);
    chk("R4", "no ovf up", AW'(wrap), 0);
    req("R4", 2'd0, 0, 0, 32'h0000_0003, 0, 0, 16'hFFFB, 0);
    chk("R4", "wrap down", res, 32'hFFFF_FFFE);
    // R5 signed overflow
    req("R5", 2'd0, 0, 0, 32'h7FFF_FFFF, 0, 0, 16'd1, 0);
    chk("R5", "pos ovf", AW'(wrap), 1);
    req("R5", 2'd0, 0, 0, 32'h8000_0000, 0, 0, 16'hFFFF, 0);
    chk("R5", "neg ovf", AW'(wrap), 1);
    // R9 arithmetic keeps flag
    req("R9", 2'd3, 0, 0, 32'h0, 32'd2, 2'd1, 16'd1, 0);
    chk("R9", "arith value", res, 32'd5);
    chk("R9", "flag kept", AW'(wrap), 1);
    chk("R9", "not addr", AW'(is_addr), 0);
    // R6 post-increment
    req("R6", 2'd1, 0, 32'hDEAD_0000, 32'h2000, 32'h55, 2'd2, 16'h7777, 0);
    chk("R6", "addr is base", res, 32'h2000);
    chk("R6", "wb data", wb_data, 32'h2004);
    chk("R6", "wb strobe", AW'(wb_en), 1);
    @(negedge clk);
    chk("R10", "wb strobe drops", AW'(wb_en), 0);
    chk("R10", "res held", res, 32'h2000);
    // R7 PC-relative
    req("R7", 2'd2, 1, 32'h1234_0000, 32'hABCD_0000, 32'h99, 2'd3, 16'hFFF0, 32'h400);
    chk("R7", "pc rel", res, 32'h3F0);
    // R8 segment on/off
    req("R8", 2'd0, 1, 32'h0001_0000, 32'h10, 0, 0, 0, 0);
    chk("R8", "seg added", res, 32'h0001_0010);
    req("R8", 2'd0, 0, 32'hFFFF_0000, 32'h10, 0, 0, 0, 0);
    chk("R8", "seg ignored", res, 32'h10);

    // random mixed traffic, checked every cycle
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      else begin
        logic [1:0] m;
        m = 2'($urandom_range(0, 3));
        req(m == 2'd1 ? "R6" : m == 2'd2 ? "R7" : m == 2'd3 ? "R9" : "R5",
            m, 1'($urandom), $urandom, $urandom, $urandom, 2'($urandom),
            16'($urandom), $urandom);
      end
    end
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule